// File: doc/BRIEF.md
# Indexed Register Port with Programmed-I/O Byte Sequencer

This block sits behind a byte-wide asynchronous host bus with a two-bit address and separate read and write strobes. Address 0 holds an index pointer and two mode bits. Address 1 reaches one of the indirect registers through that pointer. Address 2 is a status byte. Address 3 is a data port: host writes feed a playback sample and host reads drain a capture sample. Both strobes are brought into the core clock through synchronizer chains, and each access acts once, on the rising edge of the synchronized strobe.

For programmed I/O, two byte-tracking sequencers walk through a stereo sample. The order is left channel then right channel, and within a channel the upper byte comes before the lower byte. In 8-bit formats each channel takes a single byte, and in mono only the left channel is transferred. The status byte reports where each sequencer stands. A sticky interrupt flag, an initialization lockout and a mode-change gate on the format and configuration registers complete the register behaviour. Clearing the mode bit starts a calibration window lasting a fixed number of sample ticks, and capture returns midscale data while that window is open.

Top module: `hostreg_port`

## Requirements
- R1: After reset the status byte reads CCh. Once initialization is over, address 0 reads 40h: index 0, mode-change bit (bit 6) set, transfer-disable bit (bit 5) clear, and bit 7 reporting initialization.
- R2: A write to address 0 stores the index in bits 3:0. A write or read at address 1 reaches the indirect register with that index.
- R3: Indirect register 8 (format: bit 0 stereo, bit 1 16-bit) is written only while the mode-change bit is set. In indirect register 9, bits 1:0 (playback and capture enables) are writable at any time, and bits 7:2 only while the mode-change bit is set.
- R4: The interrupt flag (status bit 0, also the `irq` output) is set by `irq_evt`, stays set, and is cleared by any host write to address 2.
- R5: The status byte reports playback position. Bit 1 is 1 when a playback sample may be written. Bit 2 is 1 when the next byte is left or mono. Bit 3 is 1 when the next byte is an upper byte or the format is 8-bit. Each playback write advances in the order left upper, left lower, right upper, right lower.
- R6: Playback writes after the last byte of a sample are ignored. `play_take` presents the assembled sample on `play_left` and `play_right`, with the 8-bit byte in bits 15:8 and mono copied to the right channel. It also resets the sequencer. A take before the sample is complete gives 0000h and sets the over/underrun bit (status bit 4).
- R7: `cap_evt` loads a capture sample and points at its first byte. Each read at address 3 returns the current byte and advances in the same order as playback. Status bit 5 is 1 while bytes remain, bit 6 is 1 for left or mono, and bit 7 is 1 for an upper byte or 8-bit. After the last byte the pointer stays there, reads repeat that byte and bit 5 clears.
- R8: A capture sample that arrives while bytes of the previous sample are still unread sets status bit 4. A capture that arrives with the previous sample fully read clears it.
- R9: While `init_busy` is high, host writes are ignored and reads of addresses 0, 1 and 3 return 80h. The status byte stays readable.
- R10: Clearing the mode-change bit holds `cal_busy` high for CAL_SAMPLES ticks of `sample_tick`. Capture samples taken in that window read as 0000h.
- R11: The number of bytes in a sample follows the format: 4 for stereo 16-bit, 2 for mono 16-bit or stereo 8-bit, and 1 for mono 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| init_busy | input | 1 | Initialization in progress; locks out host writes |
| host_rd | input | 1 | Asynchronous read strobe, active high |
| host_wr | input | 1 | Asynchronous write strobe, active high |
| host_addr | input | 2 | Direct register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| irq_evt | input | 1 | One-cycle request to set the interrupt flag |
| cap_evt | input | 1 | One-cycle strobe: new capture sample |
| cap_left | input | 16 | Left capture sample |
| cap_right | input | 16 | Right capture sample |
| play_take | input | 1 | One-cycle strobe: the converter takes the playback sample |
| sample_tick | input | 1 | One pulse per sample period |
| play_left | output | 16 | Left playback sample presented at the last take |
| play_right | output | 16 | Right playback sample presented at the last take |
| irq | output | 1 | Interrupt flag |
| cal_busy | output | 1 | Calibration window open |

## Verification
A host access takes effect on the third clock edge after its strobe rises: two synchronizer flops, then the action edge, at which `host_rdata` is also loaded. The bench therefore holds each strobe high for five cycles, and the read monitor compares `host_rdata` only when the strobe falls. The one-cycle core strobes (`play_take`, `cap_evt`, `irq_evt`, `sample_tick`) act on the next edge, so their outputs are sampled on the falling clock edge that follows. Status reads issued after each event check the sequencer positions and flags, once all earlier accesses have finished.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  typedef enum logic [1:0] {
    A_INDEX  = 2'd0,
    A_IDATA  = 2'd1,
    A_STATUS = 2'd2,
    A_PIO    = 2'd3
  } dir_addr_e;

  localparam logic [7:0] LOCK_READ = 8'h80;

  // position p of the byte walk: which channel it belongs to
  function automatic logic pos_right(input logic [1:0] p, input logic stereo, input logic wide);
    return stereo & (wide ? p[1] : p[0]);
  endfunction

  // position p of the byte walk: lower byte of a 16-bit channel
  function automatic logic pos_lower(input logic [1:0] p, input logic wide);
    return wide & p[0];
  endfunction

  // last position of a sample: byte count minus one
  function automatic logic [1:0] pos_last(input logic stereo, input logic wide);
    return {stereo & wide, stereo | wide};
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/pio_play_seq.sv
module pio_play_seq import hostreg_pkg::*; #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_pulse,
  input  logic [7:0]    wdata,
  input  logic          stereo,
  input  logic          wide,
  input  logic          take,
  output logic          full,
  output logic [1:0]    pos,
  output logic          under,
  output logic [SW-1:0] left_out,
  output logic [SW-1:0] right_out
);
  logic [SW-1:0] l_q, r_q;
  logic          to_right, to_lower;

  assign to_right = pos_right(pos, stereo, wide);
  assign to_lower = pos_lower(pos, wide);

  always_ff @(posedge clk) begin
    if (rst) begin
      full      <= 1'b1;
      pos       <= '0;
      under     <= 1'b0;
      l_q       <= '0;
      r_q       <= '0;
      left_out  <= '0;
      right_out <= '0;
    end else if (take) begin
      left_out  <= full ? l_q : '0;
      right_out <= full ? (stereo ? r_q : l_q) : '0;
      under     <= ~full;
      full      <= 1'b0;
      pos       <= '0;
    end else if (wr_pulse && !full) begin
      if (!wide) begin
        if (to_right) r_q <= {wdata, 8'h00};
        else          l_q <= {wdata, 8'h00};
      end else if (to_right) begin
        if (to_lower) r_q[7:0]    <= wdata;
        else          r_q[SW-1:8] <= wdata;
      end else begin
        if (to_lower) l_q[7:0]    <= wdata;
        else          l_q[SW-1:8] <= wdata;
      end
      if (pos == pos_last(stereo, wide)) full <= 1'b1;
      else                               pos  <= pos + 2'd1;
    end
  end

  a_r6_ignore_when_full: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |=> (full && $stable(pos) && $stable(l_q) && $stable(r_q)));
  a_r6_take_rewinds: assert property (@(posedge clk) disable iff (rst)
    take |=> (!full && pos == 2'd0));
endmodule

// File: rtl/pio_cap_seq.sv
module pio_cap_seq import hostreg_pkg::*; #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_evt,
  input  logic [SW-1:0] cap_l,
  input  logic [SW-1:0] cap_r,
  input  logic          force_mid,
  input  logic          rd_pulse,
  input  logic          stereo,
  input  logic          wide,
  output logic          rdy,
  output logic [1:0]    pos,
  output logic          over,
  output logic [7:0]    byte_out
);
  logic [SW-1:0] cl_q, cr_q, chan;

  assign chan     = pos_right(pos, stereo, wide) ? cr_q : cl_q;
  assign byte_out = pos_lower(pos, wide) ? chan[7:0] : chan[SW-1:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q <= '0;
      cr_q <= '0;
      rdy  <= 1'b0;
      pos  <= '0;
      over <= 1'b0;
    end else if (cap_evt) begin
      cl_q <= force_mid ? '0 : cap_l;
      cr_q <= force_mid ? '0 : cap_r;
      over <= rdy;
      rdy  <= 1'b1;
      pos  <= '0;
    end else if (rd_pulse && rdy) begin
      if (pos == pos_last(stereo, wide)) rdy <= 1'b0;
      else                               pos <= pos + 2'd1;
    end
  end

  a_r7_new_sample: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (rdy && pos == 2'd0));
  a_r7_hold_last: assert property (@(posedge clk) disable iff (rst)
    (!rdy && !cap_evt) |=> (!rdy && $stable(pos)));
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port import hostreg_pkg::*; #(
  parameter int NREG        = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CAL_SAMPLES = 128,
  parameter int FMT_IDX     = 8,
  parameter int CFG_IDX     = 9,
  parameter int SW          = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_busy,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [1:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          irq_evt,
  input  logic          cap_evt,
  input  logic [SW-1:0] cap_left,
  input  logic [SW-1:0] cap_right,
  input  logic          play_take,
  input  logic          sample_tick,
  output logic [SW-1:0] play_left,
  output logic [SW-1:0] play_right,
  output logic          irq,
  output logic          cal_busy
);
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(CAL_SAMPLES + 1);

  logic          rd_p, wr_p, wr_ok;
  logic [IW-1:0] idx_q;
  logic          mce_q, trd_q;
  logic [7:0]    ireg [NREG];
  logic [CW-1:0] cal_cnt;
  logic          stereo, wide;
  logic          p_full, p_under, c_rdy, c_over, sour_q;
  logic [1:0]    p_pos, c_pos;
  logic [7:0]    c_byte, status, index_rd;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (.clk(clk), .rst(rst), .async_in(host_rd), .rise(rd_p));
  strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (.clk(clk), .rst(rst), .async_in(host_wr), .rise(wr_p));

  assign wr_ok  = wr_p & ~init_busy;
  assign stereo = ireg[FMT_IDX][0];
  assign wide   = ireg[FMT_IDX][1];

  pio_play_seq #(.SW(SW)) u_play (
    .clk(clk), .rst(rst),
    .wr_pulse(wr_ok && host_addr == A_PIO), .wdata(host_wdata),
    .stereo(stereo), .wide(wide), .take(play_take),
    .full(p_full), .pos(p_pos), .under(p_under),
    .left_out(play_left), .right_out(play_right));

  pio_cap_seq #(.SW(SW)) u_cap (
    .clk(clk), .rst(rst), .cap_evt(cap_evt), .cap_l(cap_left), .cap_r(cap_right),
    .force_mid(cal_busy), .rd_pulse(rd_p && !init_busy && host_addr == A_PIO),
    .stereo(stereo), .wide(wide),
    .rdy(c_rdy), .pos(c_pos), .over(c_over), .byte_out(c_byte));

  // direct register 0, interrupt flag, calibration window
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      mce_q   <= 1'b1;
      trd_q   <= 1'b0;
      irq     <= 1'b0;
      cal_cnt <= '0;
    end else begin
      if (wr_ok && host_addr == A_INDEX) begin
        idx_q <= host_wdata[IW-1:0];
        trd_q <= host_wdata[5];
        mce_q <= host_wdata[6];
      end
      if (wr_ok && host_addr == A_INDEX && mce_q && !host_wdata[6])
        cal_cnt <= CW'(CAL_SAMPLES);
      else if (sample_tick && cal_cnt != '0)
        cal_cnt <= cal_cnt - 1'b1;
      if (irq_evt)                              irq <= 1'b1;
      else if (wr_ok && host_addr == A_STATUS)  irq <= 1'b0;
    end
  end

  assign cal_busy = (cal_cnt != '0);

  // indirect registers, with mode-change gating on format and configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) ireg[i] <= '0;
    end else if (wr_ok && host_addr == A_IDATA) begin
      if (int'(idx_q) == FMT_IDX) begin
        if (mce_q) ireg[idx_q] <= host_wdata;
      end else if (int'(idx_q) == CFG_IDX) begin
        ireg[idx_q][1:0] <= host_wdata[1:0];
        if (mce_q) ireg[idx_q][7:2] <= host_wdata[7:2];
      end else begin
        ireg[idx_q] <= host_wdata;
      end
    end
  end

  // sample over/underrun follows the most recent sample event
  always_ff @(posedge clk) begin
    if (rst)                    sour_q <= 1'b0;
    else if (play_take && cap_evt) sour_q <= ~p_full | c_rdy;
    else if (play_take)         sour_q <= ~p_full;
    else if (cap_evt)           sour_q <= c_rdy;
  end

  assign status = {~pos_lower(c_pos, wide), ~pos_right(c_pos, stereo, wide), c_rdy, sour_q,
                   ~pos_lower(p_pos, wide), ~pos_right(p_pos, stereo, wide), ~p_full, irq};
  assign index_rd = {init_busy, mce_q, trd_q, 1'b0, 4'(idx_q)};

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (rd_p) begin
      unique case (dir_addr_e'(host_addr))
        A_INDEX:  host_rdata <= init_busy ? LOCK_READ : index_rd;
        A_IDATA:  host_rdata <= init_busy ? LOCK_READ : ireg[idx_q];
        A_STATUS: host_rdata <= status;
        A_PIO:    host_rdata <= init_busy ? LOCK_READ : c_byte;
      endcase
    end
  end

  a_r4_irq_cleared: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && host_addr == A_STATUS && !irq_evt) |=> !irq);
  a_r4_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wr_p && host_addr == A_STATUS)) |=> irq);
  a_r9_write_lockout: assert property (@(posedge clk) disable iff (rst)
    (init_busy && wr_p) |=> ($stable(idx_q) && $stable(mce_q) && $stable(trd_q)));
  a_r10_cal_opens: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && host_addr == A_INDEX && mce_q && !host_wdata[6]) |=> cal_busy);
  a_r3_format_locked: assert property (@(posedge clk) disable iff (rst)
    !mce_q |=> $stable(ireg[FMT_IDX]));
  a_r5_sour_from_status: assert property (@(posedge clk) disable iff (rst)
    (play_take && !cap_evt) |=> (sour_q == p_under));
  a_r8_overrun_tracks: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !play_take) |=> (sour_q == c_over));
endmodule

// File: tb/hostreg_port_tb.sv
module hostreg_port_tb_top;
  localparam int CAL = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_busy = 1'b1;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        irq_evt = 1'b0, cap_evt = 1'b0, play_take = 1'b0, sample_tick = 1'b0;
  logic [15:0] cap_left = '0, cap_right = '0;
  logic [15:0] play_left, play_right;
  logic        irq, cal_busy;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  hostreg_port #(.CAL_SAMPLES(CAL)) dut_i (
    .clk(clk), .rst(rst), .init_busy(init_busy), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_evt(irq_evt), .cap_evt(cap_evt), .cap_left(cap_left), .cap_right(cap_right),
    .play_take(play_take), .sample_tick(sample_tick),
    .play_left(play_left), .play_right(play_right), .irq(irq), .cal_busy(cal_busy));

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: read result is compared when the read strobe falls
  initial forever begin
    @(negedge host_rd);
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk({8'h00, host_rdata}, {8'h00, it.exp}, it.tag);
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    repeat (5) @(negedge clk); host_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    repeat (5) @(negedge clk); host_rd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_take();
    @(negedge clk); play_take = 1'b1; @(negedge clk); play_take = 1'b0;
  endtask
  task automatic pulse_cap(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk); cap_left = l; cap_right = r; cap_evt = 1'b1; @(negedge clk); cap_evt = 1'b0;
  endtask
  task automatic pulse_tick();
    @(negedge clk); sample_tick = 1'b1; @(negedge clk); sample_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R9 lockout and R1 reset status
    bus_rd(2'd0, 8'h80, "R9 index during init");
    bus_rd(2'd1, 8'h80, "R9 indexed data during init");
    bus_rd(2'd3, 8'h80, "R9 capture during init");
    bus_rd(2'd2, 8'hCC, "R1 status reset");
    bus_wr(2'd0, 8'h05);
    init_busy = 1'b0;
    bus_rd(2'd0, 8'h40, "R1 R9 index after init, write ignored");
    // R2 indexed access
    bus_wr(2'd0, 8'h43); bus_wr(2'd1, 8'h5A);
    bus_wr(2'd0, 8'h44); bus_wr(2'd1, 8'hA5);
    bus_wr(2'd0, 8'h43); bus_rd(2'd1, 8'h5A, "R2 indirect 3");
    bus_wr(2'd0, 8'h44); bus_rd(2'd1, 8'hA5, "R2 indirect 4");
    // R3 gating: stereo 16-bit, config F0
    bus_wr(2'd0, 8'h48); bus_wr(2'd1, 8'h03);
    bus_wr(2'd0, 8'h49); bus_wr(2'd1, 8'hF0);
    bus_wr(2'd0, 8'h08);
    chk({15'd0, cal_busy}, 16'd1, "R10 calibration opens");
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, 8'h03, "R3 format locked");
    bus_wr(2'd0, 8'h09); bus_wr(2'd1, 8'h03);
    bus_rd(2'd1, 8'hF3, "R3 enables writable, rest locked");
    // R10 midscale capture during calibration
    pulse_cap(16'h1234, 16'h5678);
    bus_rd(2'd3, 8'h00, "R10 midscale capture");
    for (int i = 0; i < CAL - 1; i++) pulse_tick();
    chk({15'd0, cal_busy}, 16'd1, "R10 still busy one tick early");
    pulse_tick();
    chk({15'd0, cal_busy}, 16'd0, "R10 window closed");
    // R7 R8 capture walk
    pulse_cap(16'h1234, 16'h5678);
    bus_rd(2'd2, 8'hFC, "R8 overrun status");
    bus_rd(2'd3, 8'h12, "R7 left upper");
    bus_rd(2'd2, 8'h7C, "R7 status at left lower");
    bus_rd(2'd3, 8'h34, "R7 left lower");
    bus_rd(2'd3, 8'h56, "R7 right upper");
    bus_rd(2'd3, 8'h78, "R7 right lower");
    bus_rd(2'd2, 8'h1C, "R7 status after last byte");
    bus_rd(2'd3, 8'h78, "R7 pointer holds last byte");
    pulse_cap(16'h9ABC, 16'hDEF0);
    bus_rd(2'd3, 8'h9A, "R7 new sample rewinds");
    bus_rd(2'd2, 8'h6C, "R8 no overrun after full read");
    // R5 R6 playback walk
    pulse_take();
    bus_rd(2'd2, 8'h6E, "R5 playback ready");
    bus_wr(2'd3, 8'h11);
    bus_rd(2'd2, 8'h66, "R5 left lower next");
    bus_wr(2'd3, 8'h22);
    bus_rd(2'd2, 8'h6A, "R5 right upper next");
    bus_wr(2'd3, 8'h33); bus_wr(2'd3, 8'h44);
    bus_rd(2'd2, 8'h60, "R5 sample complete");
    bus_wr(2'd3, 8'h55);
    pulse_take();
    @(negedge clk);
    chk(play_left, 16'h1122, "R6 left assembled");
    chk(play_right, 16'h3344, "R6 right assembled, extra write ignored");
    pulse_take();
    @(negedge clk);
    chk(play_left, 16'h0000, "R6 underrun output");
    bus_rd(2'd2, 8'h7E, "R6 underrun status");
    // R4 interrupt
    @(negedge clk); irq_evt = 1'b1; @(negedge clk); irq_evt = 1'b0;
    repeat (3) @(negedge clk);
    chk({15'd0, irq}, 16'd1, "R4 irq sticky");
    bus_rd(2'd2, 8'h7F, "R4 status bit 0");
    bus_wr(2'd2, 8'hA3);
    chk({15'd0, irq}, 16'd0, "R4 irq cleared by status write");
    // R11 mono 8-bit
    bus_wr(2'd0, 8'h48); bus_wr(2'd1, 8'h00); bus_wr(2'd0, 8'h08);
    for (int i = 0; i < CAL; i++) pulse_tick();
    pulse_take();
    bus_wr(2'd3, 8'hA7); bus_wr(2'd3, 8'hB8);
    pulse_take();
    @(negedge clk);
    chk(play_left, 16'hA700, "R11 mono 8-bit left");
    chk(play_right, 16'hA700, "R11 mono copied right");
    pulse_cap(16'hC3D4, 16'hE5F6);
    bus_rd(2'd3, 8'hC3, "R11 single capture byte");
    bus_rd(2'd2, 8'hDE, "R11 status after one byte");
    bus_rd(2'd3, 8'hC3, "R11 capture holds");
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule